// File: doc/BRIEF.md
# Shared Chunk Buffer Store Arbiter

This block decides which of eight input ports may write its next chunk into a packet buffer shared by all output queues. A chunk holds eight flits. A port raises its request once it holds a full chunk, or holds the tail flit of a packet. Each request names the output queue that the chunk belongs to. It also says whether the chunk is critical, meaning the output side has already drained every earlier chunk of that packet. The block grants at most one request per cycle. The grant is combinational from the current state. The requesting port keeps its request up until it sees its grant bit.

Storage is counted, not addressed. A common pool serves every queue on demand. Each output queue also owns one reserved emergency chunk that only a critical chunk of that queue may take. The output side reports each chunk it frees through a release strobe. A freed emergency chunk goes back to its queue's reservation. Any other freed chunk goes back to the common pool. Among the eligible requests, critical ones come first. Ties are broken by a least-recently-granted order.

Top module: `sba_store_arb`

## Requirements
- R1: After reset, free_count is NCHUNK (64), every q_occ field is 0, every q_full bit is 0, and no grant is given while no request is raised.
- R2: At most one gnt_onehot bit is set per cycle, and only for a raising port. gnt_valid is set exactly when a grant is given. gnt_queue equals the queue field of the granted port, which is bits [3i+2:3i] of req_queue for port i.
- R3: Among eligible requests of the same class, the winner is the port granted least recently. After reset the order is port 0 first through port 7 last. A granted port moves to the end of the order.
- R4: When any eligible request has req_crit set, the grant goes to a critical request, whatever the age order.
- R5: A non-critical request is eligible only while the common pool holds a chunk. Otherwise it gets no grant and stays pending, and it is granted once the pool refills. Eligibility uses the state at the start of the cycle, so a release in the same cycle does not help.
- R6: A critical request for queue q, made while the common pool is empty and q's reservation is unused, is granted with gnt_emerg = 1. A grant taken from the common pool has gnt_emerg = 0.
- R7: An emergency chunk serves only its own queue. While the pool is empty and q's reservation is spent, no request for q is granted and q_full[q] = 1. Requests for other queues are not blocked by this.
- R8: Releasing a chunk of queue q whose reservation is spent restores that reservation. This raises free_count by one, clears q_full[q] and leaves the pool empty. Any other release returns the chunk to the common pool.
- R9: q_occ[q] (bits [7q+6:7q]) rises by one per grant to q and falls by one per release of q. A grant and a release for q in the same cycle leave it unchanged.
- R10: free_count is always NCHUNK minus the sum of all q_occ. A single queue may take every pooled chunk, NCHUNK - NQUEUE = 56, plus its own emergency chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 8 | Store request per input port |
| req_crit | input | 8 | Request carries a critical chunk |
| req_queue | input | 24 | Target output queue per port, 3 bits each |
| rel_valid | input | 1 | One chunk freed by the output side |
| rel_queue | input | 3 | Queue the freed chunk belonged to |
| gnt_valid | output | 1 | A request is granted this cycle |
| gnt_onehot | output | 8 | Granted port |
| gnt_queue | output | 3 | Queue of the granted chunk |
| gnt_emerg | output | 1 | Grant consumes the queue's emergency chunk |
| free_count | output | 7 | Free chunks, pooled plus unused reservations |
| q_full | output | 8 | Queue can take no chunk at all |
| q_occ | output | 56 | Chunks held per queue, 7 bits each |

## Verification
The age order is first exercised by a shrinking request mask that drains every port in order. A later request set must then pick a port that a round-robin pointer would have skipped, and this separates least-recently-granted from plain rotation. A request set that mixes a critical chunk with an older ordinary one shows that class outranks age. Filling the pool from one queue reaches the exhaustion boundary. There, blocked ordinary requests, single use of an emergency chunk per queue, emergency use by another queue, and release both with and without a spent reservation each change free_count, q_full and the grant in a different way. A release made in the same cycle as a request shows that eligibility is decided from the state at the start of the cycle.

// File: rtl/sba_pkg.sv
package sba_pkg;
    localparam int DEF_NPORT  = 8;
    localparam int DEF_NQUEUE = 8;
    localparam int DEF_NCHUNK = 64;

    // Index of the lowest set bit, used to turn a one-hot grant into an index.
    function automatic int lowest_set(input logic [63:0] v, input int n);
        int idx;
        idx = 0;
        for (int k = n - 1; k >= 0; k--) begin
            if (v[k]) idx = k;
        end
        return idx;
    endfunction
endpackage

// File: rtl/sba_lru_arb.sv
module sba_lru_arb #(
    parameter int NPORT = 8,
    localparam int PW = $clog2(NPORT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] cand,
    output logic             gnt_valid,
    output logic [PW-1:0]    gnt_idx,
    output logic [NPORT-1:0] gnt_onehot
);
    // order_q[0] is the least recently granted port
    logic [PW-1:0] order_q [NPORT];
    logic [PW-1:0] order_d [NPORT];
    int            pos;

    always_comb begin
        gnt_valid = 1'b0;
        pos       = 0;
        for (int k = 0; k < NPORT; k++) begin
            if (!gnt_valid && cand[order_q[k]]) begin
                gnt_valid = 1'b1;
                pos       = k;
            end
        end
        gnt_idx    = order_q[pos];
        gnt_onehot = gnt_valid ? (NPORT'(1) << gnt_idx) : '0;
    end

    always_comb begin
        for (int k = 0; k < NPORT; k++) begin
            if (!gnt_valid || k < pos) order_d[k] = order_q[k];
            else if (k < NPORT - 1)    order_d[k] = order_q[k+1];
            else                       order_d[k] = gnt_idx;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NPORT; k++) begin
            if (rst) order_q[k] <= PW'(k);
            else     order_q[k] <= order_d[k];
        end
    end
endmodule

// File: rtl/sba_pool.sv
module sba_pool #(
    parameter int NQUEUE = 8,
    parameter int NCHUNK = 64,
    localparam int QW = $clog2(NQUEUE),
    localparam int CW = $clog2(NCHUNK + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 gnt_valid,
    input  logic [QW-1:0]        gnt_queue,
    input  logic                 gnt_emerg,
    input  logic                 rel_valid,
    input  logic [QW-1:0]        rel_queue,
    output logic [CW-1:0]        shared_free,
    output logic [NQUEUE-1:0]    emerg_used,
    output logic [CW-1:0]        free_count,
    output logic [NQUEUE-1:0]    q_full,
    output logic [NQUEUE*CW-1:0] q_occ
);
    logic [CW-1:0]     shared_d;
    logic [NQUEUE-1:0] emerg_d;
    logic [CW-1:0]     occ_q [NQUEUE];
    logic [CW-1:0]     occ_d [NQUEUE];
    logic              rel_to_shared;

    assign rel_to_shared = rel_valid && !emerg_used[rel_queue];

    always_comb begin
        shared_d = shared_free;
        if (gnt_valid && !gnt_emerg) shared_d = shared_d - 1'b1;
        if (rel_to_shared)           shared_d = shared_d + 1'b1;
        for (int q = 0; q < NQUEUE; q++) begin
            emerg_d[q] = emerg_used[q];
            if (gnt_valid && gnt_emerg && gnt_queue == QW'(q)) emerg_d[q] = 1'b1;
            if (rel_valid && rel_queue == QW'(q) && emerg_used[q]) emerg_d[q] = 1'b0;
            occ_d[q] = occ_q[q];
            if (gnt_valid && gnt_queue == QW'(q)) occ_d[q] = occ_d[q] + 1'b1;
            if (rel_valid && rel_queue == QW'(q)) occ_d[q] = occ_d[q] - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shared_free <= CW'(NCHUNK - NQUEUE);
            emerg_used  <= '0;
        end else begin
            shared_free <= shared_d;
            emerg_used  <= emerg_d;
        end
        for (int q = 0; q < NQUEUE; q++) begin
            if (rst) occ_q[q] <= '0;
            else     occ_q[q] <= occ_d[q];
        end
    end

    always_comb begin
        free_count = shared_free + CW'(NQUEUE) - CW'($countones(emerg_used));
        for (int q = 0; q < NQUEUE; q++) begin
            q_full[q]             = (shared_free == '0) && emerg_used[q];
            q_occ[q*CW +: CW]     = occ_q[q];
        end
    end
endmodule

// File: rtl/sba_store_arb.sv
module sba_store_arb
    import sba_pkg::*;
#(
    parameter int NPORT  = DEF_NPORT,
    parameter int NQUEUE = DEF_NQUEUE,
    parameter int NCHUNK = DEF_NCHUNK,
    localparam int QW = $clog2(NQUEUE),
    localparam int PW = $clog2(NPORT),
    localparam int CW = $clog2(NCHUNK + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NPORT-1:0]     req_valid,
    input  logic [NPORT-1:0]     req_crit,
    input  logic [NPORT*QW-1:0]  req_queue,
    input  logic                 rel_valid,
    input  logic [QW-1:0]        rel_queue,
    output logic                 gnt_valid,
    output logic [NPORT-1:0]     gnt_onehot,
    output logic [QW-1:0]        gnt_queue,
    output logic                 gnt_emerg,
    output logic [CW-1:0]        free_count,
    output logic [NQUEUE-1:0]    q_full,
    output logic [NQUEUE*CW-1:0] q_occ
);
    logic [QW-1:0]     port_q [NPORT];
    logic [NPORT-1:0]  elig;
    logic [NPORT-1:0]  crit_elig;
    logic [NPORT-1:0]  cand;
    logic [PW-1:0]     gnt_idx;
    logic [CW-1:0]     shared_free;
    logic [NQUEUE-1:0] emerg_used;
    logic              shared_nz;

    assign shared_nz = (shared_free != '0);

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        assign port_q[i] = req_queue[i*QW +: QW];
        assign elig[i]   = req_valid[i] &&
                           (shared_nz || (req_crit[i] && !emerg_used[port_q[i]]));
    end

    assign crit_elig = elig & req_crit;
    assign cand      = (|crit_elig) ? crit_elig : elig;

    sba_lru_arb #(.NPORT(NPORT)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .cand      (cand),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx),
        .gnt_onehot(gnt_onehot)
    );

    assign gnt_queue = port_q[gnt_idx];
    assign gnt_emerg = gnt_valid && !shared_nz;

    sba_pool #(.NQUEUE(NQUEUE), .NCHUNK(NCHUNK)) u_pool (
        .clk        (clk),
        .rst        (rst),
        .gnt_valid  (gnt_valid),
        .gnt_queue  (gnt_queue),
        .gnt_emerg  (gnt_emerg),
        .rel_valid  (rel_valid),
        .rel_queue  (rel_queue),
        .shared_free(shared_free),
        .emerg_used (emerg_used),
        .free_count (free_count),
        .q_full     (q_full),
        .q_occ      (q_occ)
    );
endmodule

// File: rtl/sba_store_arb_chk.sv
module sba_store_arb_chk #(
    parameter int NPORT  = 8,
    parameter int NQUEUE = 8,
    parameter int NCHUNK = 64,
    localparam int QW = $clog2(NQUEUE),
    localparam int CW = $clog2(NCHUNK + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NPORT-1:0]     req_valid,
    input logic [NPORT-1:0]     req_crit,
    input logic                 gnt_valid,
    input logic [NPORT-1:0]     gnt_onehot,
    input logic [QW-1:0]        gnt_queue,
    input logic                 gnt_emerg,
    input logic [CW-1:0]        free_count,
    input logic [NQUEUE-1:0]    q_full,
    input logic [NQUEUE*CW-1:0] q_occ,
    input logic [NPORT-1:0]     elig,
    input logic [CW-1:0]        shared_free
);
    int occ_sum;
    always_comb begin
        occ_sum = 0;
        for (int q = 0; q < NQUEUE; q++) occ_sum += int'(q_occ[q*CW +: CW]);
    end

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (rst)
        gnt_valid == ($countones(gnt_onehot) == 1) && $onehot0(gnt_onehot));

    assert_grant_requested_R2: assert property (@(posedge clk) disable iff (rst)
        (gnt_onehot & ~req_valid) == '0);

    assert_crit_first_R4: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && (gnt_onehot & req_crit) == '0) |-> (elig & req_crit) == '0);

    assert_noncrit_needs_pool_R5: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && (gnt_onehot & req_crit) == '0) |-> shared_free != '0);

    assert_emerg_only_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
        gnt_emerg |-> (shared_free == '0) && (gnt_onehot & req_crit) != '0);

    assert_full_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> !q_full[gnt_queue]);

    assert_free_balance_R10: assert property (@(posedge clk) disable iff (rst)
        int'(free_count) + occ_sum == NCHUNK);
endmodule

bind sba_store_arb sba_store_arb_chk #(.NPORT(NPORT), .NQUEUE(NQUEUE), .NCHUNK(NCHUNK)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_crit   (req_crit),
    .gnt_valid  (gnt_valid),
    .gnt_onehot (gnt_onehot),
    .gnt_queue  (gnt_queue),
    .gnt_emerg  (gnt_emerg),
    .free_count (free_count),
    .q_full     (q_full),
    .q_occ      (q_occ),
    .elig       (elig),
    .shared_free(shared_free)
);

// File: tb/sba_store_arb_tb.sv
`timescale 1ns/1ps
module sba_store_arb_tb;
    localparam int NP = 8, NQ = 8, NC = 64, QW = 3, CW = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NP-1:0]    req_valid = '0;
    logic [NP-1:0]    req_crit = '0;
    logic [NP*QW-1:0] req_queue = '0;
    logic             rel_valid = 1'b0;
    logic [QW-1:0]    rel_queue = '0;
    logic             gnt_valid;
    logic [NP-1:0]    gnt_onehot;
    logic [QW-1:0]    gnt_queue;
    logic             gnt_emerg;
    logic [CW-1:0]    free_count;
    logic [NQ-1:0]    q_full;
    logic [NQ*CW-1:0] q_occ;

    always #2.5 clk = ~clk;

    sba_store_arb u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_crit(req_crit),
        .req_queue(req_queue), .rel_valid(rel_valid), .rel_queue(rel_queue),
        .gnt_valid(gnt_valid), .gnt_onehot(gnt_onehot), .gnt_queue(gnt_queue),
        .gnt_emerg(gnt_emerg), .free_count(free_count), .q_full(q_full), .q_occ(q_occ)
    );

    int errors = 0;
    int checks = 0;
    int qsel [NP];
    int occ_m [NQ];
    bit emerg_m [NQ];
    int shared_m;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int free_m();
        int f;
        f = shared_m;
        for (int q = 0; q < NQ; q++) if (!emerg_m[q]) f++;
        return f;
    endfunction

    task automatic check_state(input string tag);
        chk(free_count == CW'(free_m()), {tag, " R10 free_count"}, free_count, free_m());
        for (int q = 0; q < NQ; q++) begin
            chk(q_occ[q*CW +: CW] == CW'(occ_m[q]), {tag, " R9 q_occ"}, q_occ[q*CW +: CW], occ_m[q]);
            chk(q_full[q] == (shared_m == 0 && emerg_m[q]), {tag, " R7 q_full"},
                q_full[q], int'(shared_m == 0 && emerg_m[q]));
        end
    endtask

    // One cycle: drive, sample at the falling edge, update the model at the rising edge.
    task automatic cyc(input logic [NP-1:0] rq, input logic [NP-1:0] cr, input bit rv,
                       input int rqq, input bit ev, input int ep, input bit ee,
                       input string tag);
        req_valid = rq;
        req_crit  = cr;
        for (int i = 0; i < NP; i++) req_queue[i*QW +: QW] = QW'(qsel[i]);
        rel_valid = rv;
        rel_queue = QW'(rqq);
        @(negedge clk);
        check_state(tag);
        chk(gnt_valid == ev, {tag, " R2 gnt_valid"}, gnt_valid, ev);
        if (ev) begin
            chk(gnt_onehot == NP'(1) << ep, {tag, " R3 gnt_onehot"}, gnt_onehot, 1 << ep);
            chk(gnt_queue == QW'(qsel[ep]), {tag, " R2 gnt_queue"}, gnt_queue, qsel[ep]);
            chk(gnt_emerg == ee, {tag, " R6 gnt_emerg"}, gnt_emerg, ee);
        end else begin
            chk(gnt_onehot == '0, {tag, " R2 no grant"}, gnt_onehot, 0);
        end
        @(posedge clk);
        if (ev) begin
            occ_m[qsel[ep]]++;
            if (ee) emerg_m[qsel[ep]] = 1'b1;
            else    shared_m--;
        end
        if (rv) begin
            occ_m[rqq]--;
            if (emerg_m[rqq]) emerg_m[rqq] = 1'b0;
            else              shared_m++;
        end
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        shared_m = NC - NQ;
        for (int q = 0; q < NQ; q++) begin occ_m[q] = 0; emerg_m[q] = 1'b0; end
        for (int i = 0; i < NP; i++) qsel[i] = i;
        cyc('0, '0, 0, 0, 0, 0, 0, "R1 reset");
    endtask

    task automatic t_lru();
        cyc(8'hFF, '0, 0, 0, 1, 0, 0, "R3 drain");
        cyc(8'hFE, '0, 0, 0, 1, 1, 0, "R3 drain");
        cyc(8'hFC, '0, 0, 0, 1, 2, 0, "R3 drain");
        cyc(8'hF8, '0, 0, 0, 1, 3, 0, "R3 drain");
        cyc(8'hF0, '0, 0, 0, 1, 4, 0, "R3 drain");
        cyc(8'hE0, '0, 0, 0, 1, 5, 0, "R3 drain");
        cyc(8'hC0, '0, 0, 0, 1, 6, 0, "R3 drain");
        cyc(8'h80, '0, 0, 0, 1, 7, 0, "R3 drain");
        cyc(8'h20, '0, 0, 0, 1, 5, 0, "R3 single");
        cyc(8'h04, '0, 0, 0, 1, 2, 0, "R3 single");
        cyc(8'hA4, '0, 0, 0, 1, 7, 0, "R3 oldest not rotation");
        cyc(8'h24, '0, 0, 0, 1, 5, 0, "R3 oldest");
        cyc(8'h04, '0, 0, 0, 1, 2, 0, "R3 oldest");
        cyc(8'h01, '0, 1, 0, 1, 0, 0, "R9 grant and release");
    endtask

    task automatic t_crit();
        cyc(8'h42, 8'h40, 0, 0, 1, 6, 0, "R4 critical over older");
        cyc(8'h02, 8'h00, 0, 0, 1, 1, 0, "R4 ordinary after");
    endtask

    task automatic t_exhaust();
        for (int q = 0; q < NQ; q++)
            while (occ_m[q] > 0) cyc('0, '0, 1, q, 0, 0, 0, "R8 drain release");
        qsel[0] = 0;
        for (int n = 0; n < NC - NQ; n++) cyc(8'h01, '0, 0, 0, 1, 0, 0, "R10 fill one queue");
        cyc(8'h01, 8'h00, 0, 0, 0, 0, 0, "R5 ordinary held");
        cyc(8'h01, 8'h01, 0, 0, 1, 0, 1, "R6 emergency grant");
        qsel[1] = 0;
        cyc(8'h03, 8'h03, 0, 0, 0, 0, 0, "R7 reservation spent");
        qsel[1] = 3;
        cyc(8'h03, 8'h03, 0, 0, 1, 1, 1, "R7 other queue reservation");
        cyc(8'h01, 8'h00, 1, 0, 0, 0, 0, "R8 restore reservation");
        cyc(8'h01, 8'h00, 0, 0, 0, 0, 0, "R8 pool still empty");
        cyc(8'h01, 8'h00, 1, 0, 0, 0, 0, "R5 same-cycle release");
        cyc(8'h01, 8'h00, 0, 0, 1, 0, 0, "R5 held request granted");
        cyc('0, '0, 0, 0, 0, 0, 0, "R10 idle");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_lru();
        t_crit();
        t_exhaust();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule